// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block turns single-cycle event pulses from a message controller into one level-sensitive interrupt line. There are four event inputs: access denied (mailbox storage touched while internal logic was updating it), external trigger, universal counter exceeded (overflow, or a watchdog count reaching zero) and receive message lost. For each event the block keeps two latched copies. A raw status bit always records the event, so software can poll for it. A flag bit records the event only when its enable bit is set, and the flag bits drive the interrupt.

Software reaches the block through a small register port with a 2-bit address, a write strobe, write data and registered read data. Writing a 1 into a bit of the flag word clears that event's flag and its status bit together. A software reset input clears all latched state in one cycle.

Top module: `evt_irq_agg`

## Requirements
- R1: A status bit sets on the clock edge that samples its event pulse, whatever the enable bit holds. Bit 0 is access denied, bit 1 is external trigger, bit 2 is counter exceeded and bit 3 is receive message lost. The same positions are used in the status, enable and flag words.
- R2: A flag bit sets only on an edge where its event pulse and its enable bit are both 1.
- R3: A write to address 2 (flag) clears both the flag bit and the status bit at every position where the write data holds 1. Positions where the write data holds 0 keep their value.
- R4: When an event pulse and a clearing write to the same bit fall in the same cycle, the event wins and the status bit stays set. The flag bit also stays set if the enable bit is 1.
- R5: Changing an enable bit leaves latched flags unchanged. Clearing an enable bit does not clear its flag, and setting an enable bit does not create a flag from an existing status bit.
- R6: A write to address 1 loads the enable word. A write to address 0 (status) has no effect on any state.
- R7: The interrupt output is registered. It rises one cycle after the first flag bit is latched, stays high while any flag bit is set, and falls one cycle after the last flag bit clears.
- R8: Read data is registered with one cycle of latency. Address 0 returns status, 1 returns enable, 2 returns flags, and 3 returns zero.
- R9: Hardware reset and software reset each clear status, enable and flag bits on the next edge and take priority over events. Hardware reset also clears the interrupt output and the read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Synchronous software reset of latched state |
| evt_i | input | 4 | Single-cycle event pulses, one per source |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 flag |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Registered read data of the address from the previous cycle |
| irq_o | output | 1 | Global interrupt, high while any flag is set |

## Verification
Status, enable and flag bits change on the edge that samples the pulse or write. Read data appears one edge after the address is presented, and the interrupt output follows one edge after the flag change. The bench drives inputs on falling edges and samples one nanosecond after rising edges. Each readback of a word therefore reflects every earlier edge. The interrupt is compared only after at least one full edge has passed since the last flag change. The directed latency tests sample the interrupt and read data on the first edge, where the old value must still be present, and again on the next edge, where the new value must appear. These tests cover both the rise and the fall of the interrupt.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // Number of event sources handled by the aggregator
    localparam int EVT_COUNT = 4;
    // Register port address width
    localparam int SEL_W     = 2;

    // Fixed bit positions shared by status, enable and flag words
    localparam int BIT_ACC_DENIED = 0;
    localparam int BIT_EXT_TRIG   = 1;
    localparam int BIT_CNT_EXCEED = 2;
    localparam int BIT_RX_LOST    = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_FLAG   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Decoded register-port write request
    typedef struct packed {
        logic                 wr;
        reg_sel_e             sel;
        logic [EVT_COUNT-1:0] data;
    } reg_req_t;

    function automatic logic is_write_to(reg_req_t req, reg_sel_e target);
        return req.wr && (req.sel == target);
    endfunction

endpackage

// File: rtl/evt_irq_cell.sv
module evt_irq_cell (
    input  logic clk,
    input  logic rst,
    input  logic sw_rst,
    input  logic evt_i,
    input  logic enable_i,
    input  logic clr_i,
    output logic status_o,
    output logic flag_o
);

    logic status_q;
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst || sw_rst) begin
            status_q <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            // Event has priority over a same-cycle clear
            if (evt_i)
                status_q <= 1'b1;
            else if (clr_i)
                status_q <= 1'b0;

            if (evt_i && enable_i)
                flag_q <= 1'b1;
            else if (clr_i)
                flag_q <= 1'b0;
        end
    end

    assign status_o = status_q;
    assign flag_o   = flag_q;

    p_status_on_event_r1: assert property (@(posedge clk) disable iff (rst)
        (evt_i && !sw_rst) |=> status_q);

    p_flag_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(evt_i && enable_i));

    p_w1c_both_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !evt_i) |=> (!status_q && !flag_q));

    p_event_beats_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_i && evt_i && !sw_rst) |=> status_q);

    p_flag_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (!evt_i && !clr_i && !sw_rst) |=> $stable(flag_q));

endmodule

// File: rtl/evt_irq_regport.sv
module evt_irq_regport
    import evt_irq_pkg::*;
#(
    parameter int N_EVT = EVT_COUNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_rst,
    input  reg_req_t         req_i,
    input  logic [N_EVT-1:0] status_i,
    input  logic [N_EVT-1:0] flag_i,
    output logic [N_EVT-1:0] enable_o,
    output logic [N_EVT-1:0] clr_o,
    output logic [N_EVT-1:0] rdata_o
);

    logic [N_EVT-1:0] enable_q;
    logic [N_EVT-1:0] rdata_q;
    logic [N_EVT-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst || sw_rst)
            enable_q <= '0;
        else if (is_write_to(req_i, SEL_ENABLE))
            enable_q <= req_i.data;
    end

    assign clr_o = is_write_to(req_i, SEL_FLAG) ? req_i.data : '0;

    always_comb begin
        unique case (req_i.sel)
            SEL_STATUS: rd_mux = status_i;
            SEL_ENABLE: rd_mux = enable_q;
            SEL_FLAG:   rd_mux = flag_i;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else
            rdata_q <= rd_mux;
    end

    assign enable_o = enable_q;
    assign rdata_o  = rdata_q;

    p_enable_load_r6: assert property (@(posedge clk) disable iff (rst)
        (is_write_to(req_i, SEL_ENABLE) && !sw_rst) |=> (enable_q == $past(req_i.data)));

    p_unused_addr_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (req_i.sel == SEL_NONE) |=> (rdata_q == '0));

endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
    import evt_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sw_rst,
    input  logic [EVT_COUNT-1:0] evt_i,
    input  logic [SEL_W-1:0]     reg_addr,
    input  logic                 reg_wr,
    input  logic [EVT_COUNT-1:0] reg_wdata,
    output logic [EVT_COUNT-1:0] reg_rdata,
    output logic                 irq_o
);

    localparam int N_EVT = EVT_COUNT;

    reg_req_t         req;
    logic [N_EVT-1:0] status_vec;
    logic [N_EVT-1:0] flag_vec;
    logic [N_EVT-1:0] enable_vec;
    logic [N_EVT-1:0] clr_vec;
    logic             irq_q;

    assign req.wr   = reg_wr;
    assign req.sel  = reg_sel_e'(reg_addr);
    assign req.data = reg_wdata;

    evt_irq_regport #(.N_EVT(N_EVT)) regport_i (
        .clk      (clk),
        .rst      (rst),
        .sw_rst   (sw_rst),
        .req_i    (req),
        .status_i (status_vec),
        .flag_i   (flag_vec),
        .enable_o (enable_vec),
        .clr_o    (clr_vec),
        .rdata_o  (reg_rdata)
    );

    for (genvar g = 0; g < N_EVT; g++) begin : g_cell
        evt_irq_cell cell_i (
            .clk      (clk),
            .rst      (rst),
            .sw_rst   (sw_rst),
            .evt_i    (evt_i[g]),
            .enable_i (enable_vec[g]),
            .clr_i    (clr_vec[g]),
            .status_o (status_vec[g]),
            .flag_o   (flag_vec[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |flag_vec;
    end

    assign irq_o = irq_q;

    p_status_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == SEL_STATUS && evt_i == '0 && !sw_rst)
            |=> $stable(status_vec) && $stable(flag_vec));

    p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(flag_vec != '0));

    p_irq_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_vec == '0) |=> !irq_o);

    p_sw_reset_r9: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (status_vec == '0 && flag_vec == '0 && enable_vec == '0));

endmodule

// File: tb/evt_irq_agg_tb.sv
module evt_irq_agg_tb_top;

    logic       clk;
    logic       rst;
    logic       sw_rst;
    logic [3:0] evt;
    logic [1:0] addr;
    logic       wr;
    logic [3:0] wdata;
    logic [3:0] rdata;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;

    evt_irq_agg dut_i (
        .clk       (clk),
        .rst       (rst),
        .sw_rst    (sw_rst),
        .evt_i     (evt),
        .reg_addr  (addr),
        .reg_wr    (wr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_o     (irq)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    // Vector: evt[22:19] wr[18] addr[17:16] wdata[15:12] exp_status[11:8] exp_enable[7:4] exp_flag[3:0]
    localparam int NV = 11;
    localparam logic [22:0] VEC [NV] = '{
        {4'h0, 1'b1, 2'd1, 4'h5, 4'h0, 4'h5, 4'h0},  // R6 load enable
        {4'h3, 1'b0, 2'd0, 4'h0, 4'h3, 4'h5, 4'h1},  // R1 R2 events 0,1
        {4'hC, 1'b0, 2'd0, 4'h0, 4'hF, 4'h5, 4'h5},  // R1 R2 events 2,3
        {4'h0, 1'b1, 2'd2, 4'h1, 4'hE, 4'h5, 4'h4},  // R3 clear bit 0
        {4'h0, 1'b1, 2'd1, 4'h0, 4'hE, 4'h0, 4'h4},  // R5 disable keeps flag
        {4'h0, 1'b1, 2'd1, 4'hF, 4'hE, 4'hF, 4'h4},  // R5 enable makes no flag
        {4'h0, 1'b1, 2'd0, 4'hF, 4'hE, 4'hF, 4'h4},  // R6 status write ignored
        {4'h0, 1'b1, 2'd2, 4'h0, 4'hE, 4'hF, 4'h4},  // R3 zeros do nothing
        {4'h0, 1'b1, 2'd2, 4'hE, 4'h0, 4'hF, 4'h0},  // R3 clear rest
        {4'h8, 1'b1, 2'd2, 4'h8, 4'h8, 4'hF, 4'h8},  // R4 event beats clear
        {4'h0, 1'b1, 2'd2, 4'hF, 4'h0, 4'hF, 4'h0}   // R3 clear all
    };

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [3:0] v);
        @(negedge clk);
        addr = a;
        wr   = 1'b0;
        @(posedge clk);
        #1;
        v = rdata;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        addr  = a;
        wr    = 1'b1;
        wdata = d;
        @(negedge clk);
        wr    = 1'b0;
        wdata = 4'h0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] v;
        rst = 1'b1; sw_rst = 1'b0; evt = 4'h0; addr = 2'd0; wr = 1'b0; wdata = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state (R9)
        check("R9 reset irq", {3'b0, irq}, 4'h0);
        read_reg(2'd0, v); check("R9 reset status", v, 4'h0);
        read_reg(2'd1, v); check("R9 reset enable", v, 4'h0);
        read_reg(2'd2, v); check("R9 reset flag", v, 4'h0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            evt   = VEC[i][22:19];
            wr    = VEC[i][18];
            addr  = VEC[i][17:16];
            wdata = VEC[i][15:12];
            @(negedge clk);
            evt   = 4'h0;
            wr    = 1'b0;
            wdata = 4'h0;
            read_reg(2'd0, v); check($sformatf("R1 R3 R4 R6 vec%0d status", i), v, VEC[i][11:8]);
            read_reg(2'd1, v); check($sformatf("R6 vec%0d enable", i), v, VEC[i][7:4]);
            read_reg(2'd2, v); check($sformatf("R2 R3 R5 vec%0d flag", i), v, VEC[i][3:0]);
            check($sformatf("R7 vec%0d irq", i), {3'b0, irq}, {3'b0, |VEC[i][3:0]});
        end

        // R8: unused address reads zero, and one-cycle read latency
        read_reg(2'd3, v); check("R8 addr3 zero", v, 4'h0);
        @(negedge clk);
        addr = 2'd1;
        #1;
        check("R8 rdata not yet updated", rdata, 4'h0);
        @(posedge clk);
        #1;
        check("R8 rdata after one edge", rdata, 4'hF);

        // R7: interrupt latency on rise and fall (enable currently 4'hF)
        @(negedge clk);
        evt = 4'h2;
        @(posedge clk);
        #1;
        check("R7 irq low on flag edge", {3'b0, irq}, 4'h0);
        @(negedge clk);
        evt = 4'h0;
        @(posedge clk);
        #1;
        check("R7 irq high next edge", {3'b0, irq}, 4'h1);
        @(negedge clk);
        addr = 2'd2; wr = 1'b1; wdata = 4'h2;
        @(posedge clk);
        #1;
        check("R7 irq still high on clear edge", {3'b0, irq}, 4'h1);
        @(negedge clk);
        wr = 1'b0; wdata = 4'h0;
        @(posedge clk);
        #1;
        check("R7 irq low after clear", {3'b0, irq}, 4'h0);

        // R9: software reset with a same-cycle event clears everything
        @(negedge clk);
        evt = 4'h5;
        @(negedge clk);
        evt = 4'h9; sw_rst = 1'b1;
        @(negedge clk);
        evt = 4'h0; sw_rst = 1'b0;
        read_reg(2'd0, v); check("R9 swrst status", v, 4'h0);
        read_reg(2'd1, v); check("R9 swrst enable", v, 4'h0);
        read_reg(2'd2, v); check("R9 swrst flag", v, 4'h0);
        check("R9 swrst irq", {3'b0, irq}, 4'h0);

        // R2: event with enable cleared sets status only
        write_reg(2'd1, 4'h0);
        @(negedge clk);
        evt = 4'h4;
        @(negedge clk);
        evt = 4'h0;
        read_reg(2'd0, v); check("R1 unmasked status", v, 4'h4);
        read_reg(2'd2, v); check("R2 no flag when disabled", v, 4'h0);
        check("R7 no irq when disabled", {3'b0, irq}, 4'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule